// File: doc/BRIEF.md
# Load-Store Reservation Station

This block is a three-entry reservation station that sits in front of a single load-store execution unit. Each cycle it can accept one dispatched instruction, together with a destination rename tag and, for each source operand, a ready bit, a tag and a value. Sources that are not yet ready are completed later by watching a result broadcast bus. Once every source of an entry is present and the unit reports that it is free, the station presents the oldest such entry on its issue port.

Unlike an ordinary station, an entry is not released when it issues. It stays occupied, and counts toward the full flag, until the unit returns a finish indication carrying that entry's destination tag. This lets the occupancy reflect operations in flight as well as those still waiting. The dispatch stage stalls on the full flag. A flush input discards every entry.

Top module: `lsrs_station`

## Requirements
- R1: After reset, and in the cycle after a flush, the station is empty: `full` is 0, `iss_valid` is 0 even with `unit_free` high, and `dealloc_valid` is 0 for any finish tag.
- R2: With `full` low, an instruction offered on `disp_valid` is stored at the next clock edge. `full` is 1 exactly when all three entries are occupied, whether waiting or issued. An instruction offered while `full` is 1 is dropped, even if a finish frees an entry in that same cycle.
- R3: `iss_valid` is 1 in a cycle only when `unit_free` is 1 and some stored, not yet issued entry has every source ready. In that cycle `iss_op`, `iss_dst_tag` and `iss_src_val` carry that entry's fields, with source 0 in the low `DATA_W` bits.
- R4: A broadcast whose tag matches a waiting source of a stored entry writes `bcast_val` into that source, and the entry can issue from the next cycle. A broadcast in the same cycle as a dispatch is captured into the new instruction's waiting sources.
- R5: When several stored entries are ready and not issued, the one dispatched earliest issues first.
- R6: An issued entry stays occupied and keeps counting toward `full` until it finishes. It is never presented on the issue port a second time.
- R7: A finish whose tag equals the destination tag of an issued entry frees that entry at the next edge and raises `dealloc_valid` in the same cycle. A finish that matches no issued entry, including one that matches an entry still waiting, changes nothing and leaves `dealloc_valid` at 0.
- R8: `flush` empties every entry at the next edge. An instruction dispatched in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all entries |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_op | input | OP_W | Operation payload of the dispatched instruction |
| disp_dst_tag | input | TAG_W | Destination rename tag |
| disp_src_rdy | input | NSRC | Per-source value already present |
| disp_src_tag | input | NSRC*TAG_W | Per-source producer tag, source 0 lowest |
| disp_src_val | input | NSRC*DATA_W | Per-source value, source 0 lowest |
| full | output | 1 | All entries occupied; dispatch must stall |
| bcast_valid | input | 1 | Result broadcast present |
| bcast_tag | input | TAG_W | Tag of the broadcast result |
| bcast_val | input | DATA_W | Broadcast result value |
| unit_free | input | 1 | Load-store unit can accept an instruction |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_op | output | OP_W | Operation of the issued entry |
| iss_dst_tag | output | TAG_W | Destination tag of the issued entry |
| iss_src_val | output | NSRC*DATA_W | Source values of the issued entry |
| fin_valid | input | 1 | Unit reports an instruction finished |
| fin_tag | input | TAG_W | Destination tag of the finished instruction |
| dealloc_valid | output | 1 | An entry is released this cycle |

## Verification
Two pairs of events can land in the same cycle. A broadcast can arrive in the same cycle as the dispatch of an instruction that waits for it. A finish can free an entry in the same cycle that a dispatch is offered while the station is full. The bench provokes both from its vector table. In the first case it checks that the new entry later issues with the broadcast value and without a second broadcast. In the second case it checks that the offered instruction was dropped: one cycle later `full` is low, and the freed slot stays empty.

// File: rtl/lsrs_pkg.sv
`timescale 1ns/1ps
package lsrs_pkg;
    // default geometry of the load-store station
    localparam int LSRS_ENTRIES = 3;
    localparam int LSRS_NSRC    = 2;
    localparam int LSRS_TAG_W   = 6;
    localparam int LSRS_DATA_W  = 32;
    localparam int LSRS_OP_W    = 6;

    // index width that never collapses to zero
    function automatic int lsrs_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lsrs_first_free.sv
`timescale 1ns/1ps
// Lowest-numbered unoccupied slot, one-hot.
module lsrs_first_free #(
    parameter int N = 3
) (
    input  logic [N-1:0] occ,
    output logic [N-1:0] free_oh,
    output logic         any_free
);
    always_comb begin
        logic seen;
        seen    = 1'b0;
        free_oh = '0;
        for (int i = 0; i < N; i++) begin
            if (!occ[i] && !seen) begin
                free_oh[i] = 1'b1;
                seen       = 1'b1;
            end
        end
        any_free = seen;
    end
endmodule

// File: rtl/lsrs_oldest_pick.sv
`timescale 1ns/1ps
// Grants the candidate with the smallest age rank (ranks are distinct).
module lsrs_oldest_pick #(
    parameter int N     = 3,
    parameter int AGE_W = 2
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][AGE_W-1:0] age,
    output logic [N-1:0]            grant,
    output logic                    any
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            grant[i] = cand[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && cand[j] && (age[j] < age[i])) begin
                    grant[i] = 1'b0;
                end
            end
        end
        any = |cand;
    end
endmodule

// File: rtl/lsrs_tag_match.sv
`timescale 1ns/1ps
// Compares a broadcast tag with every waiting source tag.
module lsrs_tag_match #(
    parameter int N     = 3,
    parameter int NSRC  = 2,
    parameter int TAG_W = 6
) (
    input  logic                            bc_valid,
    input  logic [TAG_W-1:0]                bc_tag,
    input  logic [N-1:0]                    vld,
    input  logic [N-1:0][NSRC-1:0]          rdy,
    input  logic [N-1:0][NSRC-1:0][TAG_W-1:0] stag,
    output logic [N-1:0][NSRC-1:0]          hit
);
    for (genvar e = 0; e < N; e++) begin : g_ent
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign hit[e][s] = bc_valid && vld[e] && !rdy[e][s] && (stag[e][s] == bc_tag);
        end
    end
endmodule

// File: rtl/lsrs_station.sv
`timescale 1ns/1ps
module lsrs_station
    import lsrs_pkg::*;
#(
    parameter int ENTRIES = LSRS_ENTRIES,
    parameter int NSRC    = LSRS_NSRC,
    parameter int TAG_W   = LSRS_TAG_W,
    parameter int DATA_W  = LSRS_DATA_W,
    parameter int OP_W    = LSRS_OP_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     disp_valid,
    input  logic [OP_W-1:0]          disp_op,
    input  logic [TAG_W-1:0]         disp_dst_tag,
    input  logic [NSRC-1:0]          disp_src_rdy,
    input  logic [NSRC*TAG_W-1:0]    disp_src_tag,
    input  logic [NSRC*DATA_W-1:0]   disp_src_val,
    output logic                     full,
    input  logic                     bcast_valid,
    input  logic [TAG_W-1:0]         bcast_tag,
    input  logic [DATA_W-1:0]        bcast_val,
    input  logic                     unit_free,
    output logic                     iss_valid,
    output logic [OP_W-1:0]          iss_op,
    output logic [TAG_W-1:0]         iss_dst_tag,
    output logic [NSRC*DATA_W-1:0]   iss_src_val,
    input  logic                     fin_valid,
    input  logic [TAG_W-1:0]         fin_tag,
    output logic                     dealloc_valid
);
    localparam int AGE_W = lsrs_idx_w(ENTRIES);
    localparam int CNT_W = $clog2(ENTRIES + 1);

    typedef struct packed {
        logic [ENTRIES-1:0]                         vld;
        logic [ENTRIES-1:0]                         iss;
        logic [ENTRIES-1:0][NSRC-1:0]               rdy;
        logic [ENTRIES-1:0][NSRC-1:0][TAG_W-1:0]    stag;
        logic [ENTRIES-1:0][NSRC-1:0][DATA_W-1:0]   sval;
        logic [ENTRIES-1:0][TAG_W-1:0]              dtag;
        logic [ENTRIES-1:0][OP_W-1:0]               op;
        logic [ENTRIES-1:0][AGE_W-1:0]              age;
    } st_t;

    st_t st_d, st_q;

    // dispatch operands viewed per source
    logic [0:0][NSRC-1:0]             dsp_rdy;
    logic [0:0][NSRC-1:0][TAG_W-1:0]  dsp_tag;
    logic [NSRC-1:0][DATA_W-1:0]      dsp_val;
    logic [0:0][NSRC-1:0]             dsp_hit;
    assign dsp_rdy[0] = disp_src_rdy;
    assign dsp_tag[0] = disp_src_tag;
    assign dsp_val    = disp_src_val;

    logic [ENTRIES-1:0][NSRC-1:0] fwd_hit;
    logic [ENTRIES-1:0]           cand;
    logic [ENTRIES-1:0]           iss_grant;
    logic                         any_cand;
    logic [ENTRIES-1:0]           free_oh;
    logic                         any_free;
    logic [ENTRIES-1:0]           fin_hit;
    logic                         rm_any;
    logic [AGE_W-1:0]             rm_age;
    logic [CNT_W-1:0]             occ_cnt;
    logic [AGE_W-1:0]             new_age;
    logic                         disp_take;
    logic                         iss_fire;

    lsrs_tag_match #(.N(ENTRIES), .NSRC(NSRC), .TAG_W(TAG_W)) u_fwd (
        .bc_valid (bcast_valid),
        .bc_tag   (bcast_tag),
        .vld      (st_q.vld),
        .rdy      (st_q.rdy),
        .stag     (st_q.stag),
        .hit      (fwd_hit)
    );

    lsrs_tag_match #(.N(1), .NSRC(NSRC), .TAG_W(TAG_W)) u_dsp_fwd (
        .bc_valid (bcast_valid),
        .bc_tag   (bcast_tag),
        .vld      (disp_valid),
        .rdy      (dsp_rdy),
        .stag     (dsp_tag),
        .hit      (dsp_hit)
    );

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            cand[i] = st_q.vld[i] && !st_q.iss[i] && (&st_q.rdy[i]);
        end
    end

    lsrs_oldest_pick #(.N(ENTRIES), .AGE_W(AGE_W)) u_pick (
        .cand  (cand),
        .age   (st_q.age),
        .grant (iss_grant),
        .any   (any_cand)
    );

    lsrs_first_free #(.N(ENTRIES)) u_free (
        .occ      (st_q.vld),
        .free_oh  (free_oh),
        .any_free (any_free)
    );

    // finish lookup, occupancy and the age rank of the leaving entry
    always_comb begin
        rm_age  = '0;
        occ_cnt = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            fin_hit[i] = fin_valid && st_q.vld[i] && st_q.iss[i] && (st_q.dtag[i] == fin_tag);
            if (fin_hit[i]) rm_age = rm_age | st_q.age[i];
            occ_cnt = occ_cnt + CNT_W'(st_q.vld[i]);
        end
        rm_any  = |fin_hit;
        new_age = AGE_W'(occ_cnt - CNT_W'(rm_any));
    end

    assign full      = &st_q.vld;
    assign disp_take = disp_valid && !full && any_free && !flush;
    assign iss_fire  = any_cand && unit_free && !flush;

    // issue port mux
    always_comb begin
        iss_op      = '0;
        iss_dst_tag = '0;
        iss_src_val = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (iss_grant[i]) begin
                iss_op      = iss_op | st_q.op[i];
                iss_dst_tag = iss_dst_tag | st_q.dtag[i];
                iss_src_val = iss_src_val | st_q.sval[i];
            end
        end
    end
    assign iss_valid     = iss_fire;
    assign dealloc_valid = rm_any && !flush;

    // next state
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int s = 0; s < NSRC; s++) begin
                if (fwd_hit[i][s]) begin
                    st_d.rdy[i][s]  = 1'b1;
                    st_d.sval[i][s] = bcast_val;
                end
            end
            if (iss_fire && iss_grant[i]) st_d.iss[i] = 1'b1;
            if (fin_hit[i]) begin
                st_d.vld[i] = 1'b0;
                st_d.iss[i] = 1'b0;
            end else if (rm_any && st_q.vld[i] && (st_q.age[i] > rm_age)) begin
                st_d.age[i] = st_q.age[i] - 1'b1;
            end
            if (disp_take && free_oh[i]) begin
                st_d.vld[i]  = 1'b1;
                st_d.iss[i]  = 1'b0;
                st_d.op[i]   = disp_op;
                st_d.dtag[i] = disp_dst_tag;
                st_d.age[i]  = new_age;
                for (int s = 0; s < NSRC; s++) begin
                    st_d.rdy[i][s]  = disp_src_rdy[s] || dsp_hit[0][s];
                    st_d.stag[i][s] = dsp_tag[0][s];
                    st_d.sval[i][s] = dsp_hit[0][s] ? bcast_val : dsp_val[s];
                end
            end
        end
        if (flush) begin
            st_d.vld = '0;
            st_d.iss = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !flush) |=> ($countones(st_q.vld) <= $past($countones(st_q.vld)))); // R2
    AST_ISSUE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ((iss_grant & st_q.iss) == '0)); // R6
    AST_ISSUED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !flush) |=> ((st_q.vld & st_q.iss & $past(iss_grant)) == $past(iss_grant))); // R6
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_grant)); // R5
    AST_FIN_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        dealloc_valid |=> ((st_q.vld & $past(fin_hit)) == '0)); // R7
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.vld == '0 && !full)); // R8
endmodule

// File: tb/sim_lsrs_station.sv
`timescale 1ns/1ps
module sim_lsrs_station;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        disp_valid = 1'b0;
    logic [5:0]  disp_op = '0;
    logic [5:0]  disp_dst_tag = '0;
    logic [1:0]  disp_src_rdy = '0;
    logic [11:0] disp_src_tag = '0;
    logic [63:0] disp_src_val = '0;
    logic        full;
    logic        bcast_valid = 1'b0;
    logic [5:0]  bcast_tag = '0;
    logic [31:0] bcast_val = '0;
    logic        unit_free = 1'b0;
    logic        iss_valid;
    logic [5:0]  iss_op;
    logic [5:0]  iss_dst_tag;
    logic [63:0] iss_src_val;
    logic        fin_valid = 1'b0;
    logic [5:0]  fin_tag = '0;
    logic        dealloc_valid;

    int checks = 0;
    int errors = 0;

    lsrs_station u0 (.*);

    always #10 clk = ~clk;

    typedef struct packed {
        logic        dv;
        logic [5:0]  dtag;
        logic [1:0]  srdy;
        logic [5:0]  st1;
        logic [5:0]  st0;
        logic [31:0] sv1;
        logic [31:0] sv0;
        logic        bv;
        logic [5:0]  btag;
        logic [31:0] bval;
        logic        uf;
        logic        fv;
        logic [5:0]  ftag;
        logic        x_full;
        logic        x_iss;
        logic [5:0]  x_dtag;
        logic [31:0] x_sv1;
        logic [31:0] x_sv0;
        logic        x_dea;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // dispatch A tag1 ready                                  R2
        '{1'b1, 6'd1, 2'b11, 6'd0, 6'd0, 32'd101, 32'd100, 1'b0, 6'd0, 32'd0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 32'd0, 32'd0, 1'b0},
        // dispatch B tag2, src1 waits on tag9                    R2
        '{1'b1, 6'd2, 2'b01, 6'd9, 6'd0, 32'd0, 32'd200, 1'b0, 6'd0, 32'd0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 32'd0, 32'd0, 1'b0},
        // dispatch C tag3 ready                                  R2
        '{1'b1, 6'd3, 2'b11, 6'd0, 6'd0, 32'd301, 32'd300, 1'b0, 6'd0, 32'd0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 32'd0, 32'd0, 1'b0},
        // dispatch D while full: dropped                         R2
        '{1'b1, 6'd4, 2'b11, 6'd0, 6'd0, 32'd401, 32'd400, 1'b0, 6'd0, 32'd0, 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 6'd0, 32'd0, 32'd0, 1'b0},
        // unit free: oldest ready A issues                       R5 R3
        '{1'b0, 6'd0, 2'b00, 6'd0, 6'd0, 32'd0, 32'd0, 1'b0, 6'd0, 32'd0, 1'b1, 1'b0, 6'd0, 1'b1, 1'b1, 6'd1, 32'd101, 32'd100, 1'b0},
        // broadcast tag9; B not yet eligible, C issues           R4
        '{1'b0, 6'd0, 2'b00, 6'd0, 6'd0, 32'd0, 32'd0, 1'b1, 6'd9, 32'd909, 1'b1, 1'b0, 6'd0, 1'b1, 1'b1, 6'd3, 32'd301, 32'd300, 1'b0},
        // B issues with forwarded value                          R4
        '{1'b0, 6'd0, 2'b00, 6'd0, 6'd0, 32'd0, 32'd0, 1'b0, 6'd0, 32'd0, 1'b1, 1'b0, 6'd0, 1'b1, 1'b1, 6'd2, 32'd909, 32'd200, 1'b0},
        // all issued: no reissue, still full                     R6
        '{1'b0, 6'd0, 2'b00, 6'd0, 6'd0, 32'd0, 32'd0, 1'b0, 6'd0, 32'd0, 1'b1, 1'b0, 6'd0, 1'b1, 1'b0, 6'd0, 32'd0, 32'd0, 1'b0},
        // finish C: dealloc now                                  R7
        '{1'b0, 6'd0, 2'b00, 6'd0, 6'd0, 32'd0, 32'd0, 1'b0, 6'd0, 32'd0, 1'b0, 1'b1, 6'd3, 1'b1, 1'b0, 6'd0, 32'd0, 32'd0, 1'b1},
        // dispatch E waiting 7,8 with broadcast 7 same cycle     R4
        '{1'b1, 6'd5, 2'b00, 6'd8, 6'd7, 32'd0, 32'd0, 1'b1, 6'd7, 32'd707, 1'b1, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 32'd0, 32'd0, 1'b0},
        // broadcast 8; E not yet eligible                        R4
        '{1'b0, 6'd0, 2'b00, 6'd0, 6'd0, 32'd0, 32'd0, 1'b1, 6'd8, 32'd808, 1'b1, 1'b0, 6'd0, 1'b1, 1'b0, 6'd0, 32'd0, 32'd0, 1'b0},
        // E issues with both forwarded values                    R4
        '{1'b0, 6'd0, 2'b00, 6'd0, 6'd0, 32'd0, 32'd0, 1'b0, 6'd0, 32'd0, 1'b1, 1'b0, 6'd0, 1'b1, 1'b1, 6'd5, 32'd808, 32'd707, 1'b0},
        // finish of unknown tag ignored                          R7
        '{1'b0, 6'd0, 2'b00, 6'd0, 6'd0, 32'd0, 32'd0, 1'b0, 6'd0, 32'd0, 1'b1, 1'b1, 6'd4, 1'b1, 1'b0, 6'd0, 32'd0, 32'd0, 1'b0},
        // finish A and dispatch F while full: F dropped          R2 R7
        '{1'b1, 6'd6, 2'b11, 6'd0, 6'd0, 32'd601, 32'd600, 1'b0, 6'd0, 32'd0, 1'b1, 1'b1, 6'd1, 1'b1, 1'b0, 6'd0, 32'd0, 32'd0, 1'b1},
        // F absent: not full, nothing to issue                   R2
        '{1'b0, 6'd0, 2'b00, 6'd0, 6'd0, 32'd0, 32'd0, 1'b0, 6'd0, 32'd0, 1'b1, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 32'd0, 32'd0, 1'b0}
    };

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        flush = 1'b0; disp_valid = 1'b0; disp_src_rdy = '0; disp_src_tag = '0; disp_src_val = '0;
        bcast_valid = 1'b0; unit_free = 1'b0; fin_valid = 1'b0; fin_tag = '0;
    endtask

    task automatic dispatch(input logic [5:0] t, input logic [1:0] r, input logic [5:0] t1, input logic [5:0] t0,
                            input logic [31:0] v1, input logic [31:0] v0);
        disp_valid = 1'b1; disp_dst_tag = t; disp_op = t; disp_src_rdy = r;
        disp_src_tag = {t1, t0}; disp_src_val = {v1, v0};
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk); idle(); unit_free = 1'b1; fin_valid = 1'b1; fin_tag = 6'd1; #5;
        check("R1", "full", full, 0);
        check("R1", "iss_valid", iss_valid, 0);
        check("R1", "dealloc", dealloc_valid, 0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            idle();
            if (VECS[k].dv) dispatch(VECS[k].dtag, VECS[k].srdy, VECS[k].st1, VECS[k].st0, VECS[k].sv1, VECS[k].sv0);
            bcast_valid = VECS[k].bv; bcast_tag = VECS[k].btag; bcast_val = VECS[k].bval;
            unit_free = VECS[k].uf; fin_valid = VECS[k].fv; fin_tag = VECS[k].ftag;
            #5;
            check("R2", $sformatf("full v%0d", k), full, VECS[k].x_full);
            check("R3", $sformatf("iss_valid v%0d", k), iss_valid, VECS[k].x_iss);
            check("R7", $sformatf("dealloc v%0d", k), dealloc_valid, VECS[k].x_dea);
            if (VECS[k].x_iss) begin
                check("R5", $sformatf("iss_dst_tag v%0d", k), iss_dst_tag, VECS[k].x_dtag);
                check("R3", $sformatf("iss_op v%0d", k), iss_op, VECS[k].x_dtag);
                check("R4", $sformatf("iss_src_val v%0d", k), iss_src_val, {VECS[k].x_sv1, VECS[k].x_sv0});
            end
        end

        // state: B (tag2) and E (tag5) issued, one slot free
        // R7: finish of a waiting entry is ignored
        @(negedge clk); idle(); dispatch(6'd10, 2'b00, 6'd21, 6'd20, 32'd0, 32'd0);
        @(negedge clk); idle(); fin_valid = 1'b1; fin_tag = 6'd10; unit_free = 1'b1; #5;
        check("R7", "finish on waiting entry", dealloc_valid, 0);
        check("R2", "full with issued entries", full, 1);
        @(negedge clk); idle(); bcast_valid = 1'b1; bcast_tag = 6'd20; bcast_val = 32'hA20;
        @(negedge clk); idle(); bcast_valid = 1'b1; bcast_tag = 6'd21; bcast_val = 32'hA21;
        @(negedge clk); idle(); unit_free = 1'b1; #5;
        check("R7", "waiting entry kept, issues", iss_valid, 1);
        check("R3", "iss tag", iss_dst_tag, 6'd10);
        check("R4", "iss values", iss_src_val, {32'hA21, 32'hA20});

        // R8: flush with dispatch in the same cycle
        @(negedge clk); idle(); fin_valid = 1'b1; fin_tag = 6'd2; #5;
        check("R7", "finish B", dealloc_valid, 1);
        @(negedge clk); idle(); flush = 1'b1; dispatch(6'd11, 2'b11, 6'd0, 6'd0, 32'd1, 32'd2);
        @(negedge clk); idle(); unit_free = 1'b1; fin_valid = 1'b1; fin_tag = 6'd5; #5;
        check("R8", "no issue after flush", iss_valid, 0);
        check("R8", "finish after flush", dealloc_valid, 0);
        check("R1", "empty after flush", full, 0);

        @(negedge clk); idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule